// File: doc/BRIEF.md
# Bit-Serial Two-Port Adaptor Section with Retimed Delays

This block is one symmetric two-port adaptor of a wave digital filter, built bit-serially. Two incident waves enter on single-bit lines, least significant bit first, in two's complement, one bit per clock. A strobe marks bit 0 of every word, and words follow each other with no gap. The block returns the two reflected waves on two single-bit lines in the same format.

The arithmetic is a serial subtractor that forms the port difference, a serial-parallel multiplier that scales the difference by a static coefficient, and two serial adders that add the scaled difference back onto the opposite input. The section's delay element has been retimed into the arithmetic. The subtractor takes one clock, the multiplier takes the coefficient width minus one, and each output adder takes one. Plain flip-flops make up the rest of the word, so each result word leaves in the word slot that directly follows its input word. The multiplier shifts out the discarded low product bits while the next word is already arriving. To allow this, it runs two accumulator lanes in turn.

The coefficient port carries the negated adaptor coefficient k, with value k / 2^(WC-1). Because of this fold, the input stage is a subtractor and the output stages are plain adders.

Top module: `adaptor_top`

## Requirements
- R1: While rst_ni is low, b1_o and b2_o are 0, whatever the inputs do.
- R2: word_start_i is high exactly on bit 0 of each word, and word starts are W cycles apart. The input word that starts in cycle n gives a b1 word whose bit i appears on b1_o in cycle n+W+i. That word equals (a2 + p) mod 2^W, where p = floor(k·d / 2^(WC-1)) mod 2^W and d is the signed W-bit value of (a1 − a2) mod 2^W.
- R3: With the same timing as R2, the b2 word equals (a1 + p) mod 2^W.
- R4: With k = 0, each b1 word equals its a2 word and each b2 word equals its a1 word.
- R5: The scaled difference is rounded toward minus infinity. For example, with k = −1, a1 = 1 and a2 = 0, the block gives b1 = all ones and b2 = 0.
- R6: The port difference wraps modulo 2^W. For example, a1 = 0x7FFFFF and a2 = 0x800000 give d = −1 at W = 24.
- R7: Words sent back to back each give their own result, with no carry, sign or accumulator state leaking from one word into the next.
- R8: The coefficient extremes k = +(2^(WC-1)−1) and k = −(2^(WC-1)−1) give results that follow the formulas of R2 and R3 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_start_i | input | 1 | High with bit 0 of each input word |
| coef_i | input | WC | Negated adaptor coefficient k, signed, weight 2^-(WC-1) |
| a1_i | input | 1 | Incident wave at port 1, LSB first |
| a2_i | input | 1 | Incident wave at port 2, LSB first |
| b1_o | output | 1 | Reflected wave at port 1, LSB first, one word later |
| b2_o | output | 1 | Reflected wave at port 2, LSB first, one word later |

## Verification
The assertions assume that word starts arrive exactly W cycles apart once the first one has been seen. They also assume the coefficient does not change while a multiplier lane is still in its sign-extension steps. Given those assumptions, at most one lane drives the product at a time, and a lane never restarts while it is busy. During sign extension, each lane feeds the last data bit of the difference into its accumulator and holds it there. The stimulus keeps the strobe on a strict word grid by padding with zero words. Before every coefficient change it sends a throw-away word and excludes that word from checking.

// File: rtl/adaptor_pkg.sv
package adaptor_pkg;

  // One-bit full adder: returns {carry_out, sum}.
  function automatic logic [1:0] fa_bit(input logic x, input logic y, input logic c);
    fa_bit = {(x & y) | (x & c) | (y & c), x ^ y ^ c};
  endfunction

endpackage

// File: rtl/bit_delay.sv
module bit_delay #(
  parameter int N = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (N == 0) begin : g_wire
      assign q_o = d_i;
    end else begin : g_regs
      logic [N-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sr_q <= '0;
        end else begin
          sr_q[0] <= d_i;
          for (int k = 1; k < N; k++) sr_q[k] <= sr_q[k-1];
        end
      end
      assign q_o = sr_q[N-1];
    end
  endgenerate
endmodule

// File: rtl/ser_addsub.sv
module ser_addsub
  import adaptor_pkg::*;
#(
  parameter bit SUB = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,   // high on bit 0 of the word
  input  logic x_i,
  input  logic y_i,
  output logic s_o      // registered: one cycle latency
);
  logic yv, cin, c_q, s_q;
  logic [1:0] r;

  generate
    if (SUB) begin : g_sub
      assign yv  = ~y_i;
      assign cin = clr_i ? 1'b1 : c_q;
    end else begin : g_add
      assign yv  = y_i;
      assign cin = clr_i ? 1'b0 : c_q;
    end
  endgenerate

  assign r = fa_bit(x_i, yv, cin);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q <= 1'b0;
      s_q <= 1'b0;
    end else begin
      c_q <= r[1];
      s_q <= r[0];
    end
  end

  assign s_o = s_q;
endmodule

// File: rtl/sp_mult.sv
module sp_mult #(
  parameter int W  = 24,
  parameter int WC = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,  // high with bit 0 of x
  input  logic signed [WC-1:0] coef_i,
  input  logic                 x_i,
  output logic                 p_o,      // product bit, WC-1 cycles after x bit
  output logic [1:0]           lane_start_o,
  output logic [1:0]           lane_busy_o,
  output logic [1:0]           lane_oval_o,
  output logic [1:0]           lane_xbit_o,
  output logic [1:0]           lane_ext_o
);
  localparam int LAST  = W + WC - 2;     // final step index of a lane
  localparam int SW    = $clog2(LAST + 1);
  localparam int AW    = WC + 1;
  localparam int TRUNC = WC - 1;
  localparam logic [SW-1:0] W_S     = SW'(W);
  localparam logic [SW-1:0] WM1_S   = SW'(W - 1);
  localparam logic [SW-1:0] LAST_S  = SW'(LAST);
  localparam logic [SW-1:0] TRUNC_S = SW'(TRUNC);

  logic par_q;
  logic signed [AW-1:0] kext;
  logic [1:0] lane_bit;

  assign kext = {coef_i[WC-1], coef_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      par_q <= 1'b0;
    else if (start_i) par_q <= ~par_q;
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic                 act_q, sgn_q, go, run, xb;
    logic [SW-1:0]        stp_q, cur;
    logic signed [AW-1:0] acc_q, base, s;

    assign go   = start_i && (par_q == 1'(l));
    assign run  = go | act_q;
    assign cur  = go ? '0 : stp_q;
    assign base = go ? '0 : acc_q;
    assign xb   = (cur < W_S) ? x_i : sgn_q;   // sign extension past MSB
    assign s    = base + (xb ? kext : '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q <= 1'b0;
        stp_q <= '0;
        acc_q <= '0;
        sgn_q <= 1'b0;
      end else if (run) begin
        act_q <= (cur != LAST_S);
        stp_q <= cur + SW'(1);
        acc_q <= s >>> 1;
        if (cur == WM1_S) sgn_q <= x_i;
      end
    end

    assign lane_bit[l]     = s[0];
    assign lane_start_o[l] = go;
    assign lane_busy_o[l]  = act_q;
    assign lane_oval_o[l]  = run && (cur >= TRUNC_S);
    assign lane_xbit_o[l]  = xb;
    assign lane_ext_o[l]   = run && (cur >= W_S);
  end

  assign p_o = |(lane_oval_o & lane_bit);
endmodule

// File: rtl/adaptor_top.sv
module adaptor_top #(
  parameter int W  = 24,
  parameter int WC = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 word_start_i,
  input  logic signed [WC-1:0] coef_i,
  input  logic                 a1_i,
  input  logic                 a2_i,
  output logic                 b1_o,
  output logic                 b2_o
);
  localparam int MUL_LAT = WC - 1;
  localparam int ALIGN   = 1 + MUL_LAT;       // subtractor + multiplier
  localparam int RESID   = W - ALIGN - 1;     // left of the loop delay

  logic       d_bit, p_bit, sync_mul, sync_out;
  logic [1:0] lane_start, lane_busy, lane_oval, lane_xbit, lane_ext;
  logic [1:0] a_in, a_al, b_raw, b_q;

  // Port difference a1 - a2 (negation folded into a subtractor).
  ser_addsub #(.SUB(1'b1)) u_diff (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(word_start_i),
    .x_i(a1_i), .y_i(a2_i), .s_o(d_bit)
  );

  bit_delay #(.N(1)) u_sync_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(word_start_i), .q_o(sync_mul)
  );

  bit_delay #(.N(ALIGN)) u_sync_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(word_start_i), .q_o(sync_out)
  );

  sp_mult #(.W(W), .WC(WC)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(sync_mul), .coef_i(coef_i),
    .x_i(d_bit), .p_o(p_bit),
    .lane_start_o(lane_start), .lane_busy_o(lane_busy),
    .lane_oval_o(lane_oval), .lane_xbit_o(lane_xbit), .lane_ext_o(lane_ext)
  );

  // Index 0: b1 = a2 + p ; index 1: b2 = a1 + p
  assign a_in = {a1_i, a2_i};

  for (genvar j = 0; j < 2; j++) begin : g_branch
    bit_delay #(.N(ALIGN)) u_align (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(a_in[j]), .q_o(a_al[j])
    );
    ser_addsub #(.SUB(1'b0)) u_add (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(sync_out),
      .x_i(a_al[j]), .y_i(p_bit), .s_o(b_raw[j])
    );
    bit_delay #(.N(RESID)) u_resid (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(b_raw[j]), .q_o(b_q[j])
    );
  end

  assign b1_o = b_q[0];
  assign b2_o = b_q[1];
endmodule

// File: rtl/adaptor_chk.sv
module adaptor_chk #(
  parameter int W = 24
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       word_start_i,
  input logic       d_bit,
  input logic [1:0] lane_start,
  input logic [1:0] lane_busy,
  input logic [1:0] lane_oval,
  input logic [1:0] lane_xbit,
  input logic [1:0] lane_ext
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (word_start_i) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 32'hFFFF_FFFF) begin
      gap_q <= gap_q + 32'd1;
    end
  end

  // R2: word starts sit on a strict grid of W cycles
  p_word_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_start_i && seen_q) |-> (gap_q == 32'(W - 1)));

  // R7: a lane is never restarted while it still owns a word
  p_lane_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_start & lane_busy) == 2'b00);

  // R7: at most one lane drives the product bit
  p_one_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane_oval));

  // R5: sign extension takes the last difference bit ...
  p_ext_sign0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lane_ext[0]) |-> (lane_xbit[0] == $past(d_bit)));
  p_ext_sign1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lane_ext[1]) |-> (lane_xbit[1] == $past(d_bit)));

  // R5: ... and holds it through the extension steps
  p_ext_hold0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_ext[0] && $past(lane_ext[0])) |-> $stable(lane_xbit[0]));
  p_ext_hold1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_ext[1] && $past(lane_ext[1])) |-> $stable(lane_xbit[1]));
endmodule

bind adaptor_top adaptor_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .word_start_i(word_start_i), .d_bit(d_bit),
  .lane_start(lane_start), .lane_busy(lane_busy), .lane_oval(lane_oval),
  .lane_xbit(lane_xbit), .lane_ext(lane_ext)
);

// File: tb/test_adaptor_top.sv
module test_adaptor_top;
  localparam int W  = 24;
  localparam int WC = 10;

  typedef struct {
    logic [W-1:0] e1;
    logic [W-1:0] e2;
    bit           skip;
    string        t1;
    string        t2;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_start = 1'b0;
  logic signed [WC-1:0] coef = '0;
  logic a1 = 1'b0, a2 = 1'b0;
  logic b1, b2;

  item_t q[$];
  int n_run = 0, n_fail = 0, n_word = 0;
  int cur_k = 0;
  bit started = 1'b0, drv_done = 1'b0, mon_done = 1'b0;
  event go;

  always #4 clk = ~clk;   // 125 MHz

  adaptor_top #(.W(W), .WC(WC)) i_adaptor_top (
    .clk_i(clk), .rst_ni(rst_n), .word_start_i(word_start), .coef_i(coef),
    .a1_i(a1), .a2_i(a2), .b1_o(b1), .b2_o(b2)
  );

  // keep + floor(k*(x1-x2)/2^(WC-1)), all wrapped to W bits
  function automatic logic [W-1:0] ref_out(input logic [W-1:0] keep,
      input logic [W-1:0] x1, input logic [W-1:0] x2, input int k);
    logic [W-1:0] diff;
    longint ds, prod, p;
    diff = x1 - x2;
    ds   = longint'($signed(diff));
    prod = ds * longint'(k);
    p    = prod / 512;
    if ((prod % 512 != 0) && (prod < 0)) p = p - 1;
    return keep + p[W-1:0];
  endfunction

  task automatic drive_word(input logic [W-1:0] x1, input logic [W-1:0] x2);
    for (int i = 0; i < W; i++) begin
      @(posedge clk);
      #1;
      word_start = (i == 0);
      a1 = x1[i];
      a2 = x2[i];
      if (i == 0 && !started) begin
        started = 1'b1;
        -> go;
      end
    end
  endtask

  task automatic send(input logic [W-1:0] x1, input logic [W-1:0] x2,
                      input string t1, input string t2);
    item_t it;
    it.e1 = ref_out(x2, x1, x2, cur_k);
    it.e2 = ref_out(x1, x1, x2, cur_k);
    it.skip = 1'b0;
    it.t1 = t1;
    it.t2 = t2;
    q.push_back(it);
    drive_word(x1, x2);
  endtask

  // throw-away word, then new coefficient
  task automatic set_k(input int k);
    item_t it;
    it.e1 = '0; it.e2 = '0; it.skip = 1'b1; it.t1 = ""; it.t2 = "";
    q.push_back(it);
    drive_word('0, '0);
    cur_k = k;
    coef = WC'(k);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // Monitor: collects each output word and compares with the scoreboard
  initial begin
    logic [W-1:0] r1, r2;
    item_t it;
    @go;
    repeat (W) @(posedge clk);
    forever begin
      for (int i = 0; i < W; i++) begin
        @(negedge clk);
        r1[i] = b1;
        r2[i] = b2;
      end
      it = q.pop_front();
      if (!it.skip) begin
        n_run++;
        if (r1 !== it.e1) begin
          n_fail++;
          $display("FAIL %s b1 word %0d: got %h expected %h", it.t1, n_word, r1, it.e1);
        end
        n_run++;
        if (r2 !== it.e2) begin
          n_fail++;
          $display("FAIL %s b2 word %0d: got %h expected %h", it.t2, n_word, r2, it.e2);
        end
      end
      n_word++;
      if (drv_done && q.size() == 0) begin
        mon_done = 1'b1;
        break;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!mon_done) begin
      n_run++;
      n_fail++;
      $display("FAIL R2 watchdog: words seen %0d expected %0d", n_word, n_word + q.size());
      summary();
    end
  end

  initial begin
    // R1: outputs stay low while reset is held, inputs toggling
    a1 = 1'b1; a2 = 1'b0; word_start = 1'b1; coef = 10'sd100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_run++;
    if (b1 !== 1'b0 || b2 !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: got %b%b expected 00", b1, b2);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1; a1 = 1'b0; a2 = 1'b0; word_start = 1'b0;
    cur_k = 0; coef = '0;

    // R4: zero coefficient crosses the ports
    send(24'd123456, 24'(-70000), "R4", "R4");
    send(24'hFFFFFF, 24'd5,       "R4", "R4");

    // R2/R3: half coefficient, assorted words; R7 back to back
    set_k(256);
    send(24'd1000,    24'd200,     "R2", "R3");
    send(24'(-4096),  24'd777,     "R2", "R3");
    send(24'h3ABCDE,  24'h012345,  "R7", "R7");
    send(24'h012345,  24'h3ABCDE,  "R7", "R7");

    // R5: rounding toward minus infinity
    set_k(-1);
    send(24'd1, 24'd0, "R5", "R5");
    send(24'd0, 24'd1, "R5", "R5");
    set_k(-300);
    send(24'd7, 24'd3, "R5", "R5");

    // R6: wrapping difference
    set_k(300);
    send(24'h7FFFFF, 24'h800000, "R6", "R6");
    send(24'h800000, 24'h000001, "R6", "R6");

    // R8: coefficient extremes
    set_k(511);
    send(24'h123456, 24'hFEDCBA, "R8", "R8");
    set_k(-511);
    send(24'h400000, 24'hC00000, "R8", "R8");
    send(24'h0000FF, 24'h7FFF00, "R8", "R8");

    drv_done = 1'b1;
    while (!mon_done) drive_word('0, '0);
    summary();
  end
endmodule